// File: doc/BRIEF.md
# Temperature Limit Status and Alert Latch

This block watches two 8-bit two's-complement temperature readings, one from the die and one from an external diode. It compares each reading against its own pair of programmable limits and keeps the results as sticky fault flags in a status byte. A fifth flag records an open-circuit remote sensor. Any raised flag sets an alert latch, which drives an active-low alert line. Software can mask that line with a configuration bit.

The surrounding logic supplies several single-cycle strobes:
- one that marks a fresh conversion result;
- one that marks a write to a limit register;
- one that marks a read of the status byte;
- one that marks the point where the host has finished servicing the alert-response cycle.

A status read returns the flags as they stood before that read. It then clears only the flags whose fault has gone away. The alert latch is not affected by the read. It drops only on the service strobe, and only once every flag is clear. After reset, the block compares its inputs once without waiting for a strobe. With the power-up defaults (readings 0x80, low limits 0xC9) this raises both low flags, even when the converter is idle.

Top module: `temp_alarm_status`

## Requirements
- R1: While reset is asserted, `status_q` is 0x00 and `alert_n` is 1.
- R2: The status byte layout is as follows: bit 7 busy, bit 6 local high, bit 5 local low, bit 4 remote high, bit 3 remote low, bit 2 remote open-circuit, bits 1..0 always 0.
- R3: On an evaluation, a high flag sets when reading > limit and a low flag sets when reading < limit. Both compares are signed 8-bit and strict, so equality never trips. The open flag sets when `sensor_open` is 1.
- R4: A flag stays set when its fault disappears, and stays set across further evaluations, until a status read.
- R5: A `status_rd` pulse loads `status_q` at that clock edge with busy and the flags as they stood before the edge. At the same edge it clears each flag whose condition is false at that moment. Flags whose condition is still true are kept.
- R6: The alert latch sets on the clock edge after any flag is set, which pulls `alert_n` to 0. A status read does not clear it.
- R7: An `ara_done` pulse clears the alert latch only if all five flags are 0. Otherwise the latch stays set.
- R8: When `alert_mask` is 1, `alert_n` is 1 whatever the latch holds. This covers an alert already latched as well as later ones.
- R9: An evaluation happens on a `result_valid` pulse, on a `limit_wr` pulse, and once on the first clock edge after reset. With readings 0x80 and default limits, that first edge sets both low flags, so status reads 0x28.
- R10: Changing a limit input without `limit_wr` or `result_valid` sets no flag. A `limit_wr` pulse compares against the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_val | input | 8 | Die temperature reading, two's complement |
| remote_val | input | 8 | Remote temperature reading, two's complement |
| local_hi | input | 8 | Die high limit |
| local_lo | input | 8 | Die low limit |
| remote_hi | input | 8 | Remote high limit |
| remote_lo | input | 8 | Remote low limit |
| sensor_open | input | 1 | Remote sensor detected open-circuit |
| result_valid | input | 1 | Strobe: new readings present |
| limit_wr | input | 1 | Strobe: a limit was written |
| busy | input | 1 | Converter busy, reported in status bit 7 |
| status_rd | input | 1 | Strobe: status byte read |
| ara_done | input | 1 | Strobe: alert-response cycle serviced |
| alert_mask | input | 1 | 1 forces the alert output inactive |
| status_q | output | 8 | Status byte captured by the last read |
| alert_n | output | 1 | Active-low alert |

## Verification
The assertions assume that every strobe is a clean one-cycle pulse synchronous to `clk`. They also assume that the readings and limits are stable around the edge where a strobe is sampled, so the condition seen at a read is the one the flags were cleared against. The bench meets these assumptions by changing all inputs only on the falling edge and raising each strobe for exactly one cycle. It then sweeps all 256 reading codes against limits that place the boundaries at negative values, at equality and at positive values, and compares each result with a model computed from integer arithmetic.

// File: rtl/temp_alarm_status.sv
module temp_alarm_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] local_val,
  input  logic [W-1:0] remote_val,
  input  logic [W-1:0] local_hi,
  input  logic [W-1:0] local_lo,
  input  logic [W-1:0] remote_hi,
  input  logic [W-1:0] remote_lo,
  input  logic         sensor_open,
  input  logic         result_valid,
  input  logic         limit_wr,
  input  logic         busy,
  input  logic         status_rd,
  input  logic         ara_done,
  input  logic         alert_mask,
  output logic [W-1:0] status_q,
  output logic         alert_n
);
  localparam int NF  = 5;
  localparam int PAD = W - NF - 1;

  logic [NF-1:0] cond, flags, flags_nxt;
  logic          init_eval, alert_latch, evaluate;

  assign cond = {$signed(local_val)  > $signed(local_hi),
                 $signed(local_val)  < $signed(local_lo),
                 $signed(remote_val) > $signed(remote_hi),
                 $signed(remote_val) < $signed(remote_lo),
                 sensor_open};

  assign evaluate  = result_valid | limit_wr | init_eval;
  assign flags_nxt = (status_rd ? (flags & cond) : flags) | (evaluate ? cond : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_eval   <= 1'b1;
      flags       <= '0;
      alert_latch <= 1'b0;
      status_q    <= '0;
    end else begin
      init_eval   <= 1'b0;
      flags       <= flags_nxt;
      alert_latch <= (|flags) | (alert_latch & ~ara_done);
      if (status_rd) status_q <= {busy, flags, {PAD{1'b0}}};
    end
  end

  assign alert_n = ~(alert_latch & ~alert_mask);
endmodule

module temp_alarm_status_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         status_rd,
  input logic         ara_done,
  input logic         alert_mask,
  input logic         alert_n,
  input logic [W-1:0] status_q,
  input logic [4:0]   flags,
  input logic [4:0]   cond,
  input logic         alert_latch
);
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[1:0] == 2'b00);

  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd |=> ((flags & $past(flags)) == $past(flags)));

  assert_read_keeps_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> ((flags & $past(cond)) == ($past(flags) & $past(cond))));

  assert_latch_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags) |=> alert_latch);

  assert_ara_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ara_done && (flags != 5'd0) && alert_latch) |=> alert_latch);

  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alert_mask |-> alert_n);
endmodule

bind temp_alarm_status temp_alarm_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_rd(status_rd), .ara_done(ara_done),
  .alert_mask(alert_mask), .alert_n(alert_n), .status_q(status_q),
  .flags(flags), .cond(cond), .alert_latch(alert_latch)
);

// File: tb/temp_alarm_status_bench.sv
module temp_alarm_status_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] local_val, remote_val, local_hi, local_lo, remote_hi, remote_lo;
  logic sensor_open = 0, result_valid = 0, limit_wr = 0, busy = 0;
  logic status_rd = 0, ara_done = 0, alert_mask = 0;
  logic [7:0] status_q;
  logic alert_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  temp_alarm_status u_temp_alarm_status (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_rv();   result_valid = 1; @(negedge clk); result_valid = 0; endtask
  task automatic pulse_lw();   limit_wr = 1;     @(negedge clk); limit_wr = 0;     endtask
  task automatic pulse_rd();   status_rd = 1;    @(negedge clk); status_rd = 0;    endtask
  task automatic pulse_ara();  ara_done = 1;     @(negedge clk); ara_done = 0;     endtask

  function automatic int sx(input logic [7:0] b);
    return (b >= 8'd128) ? int'(b) - 256 : int'(b);
  endfunction

  initial begin
    local_val = 8'h80; remote_val = 8'h80;
    local_hi = 8'h7F; remote_hi = 8'h7F; local_lo = 8'hC9; remote_lo = 8'hC9;
    repeat (3) @(negedge clk);
    chk("R1 status", status_q, 8'h00);
    chk("R1 alert", {7'd0, alert_n}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    pulse_rd();
    chk("R9 power-up low flags", status_q, 8'h28);
    chk("R6 alert after read", {7'd0, alert_n}, 8'h00);
    pulse_ara();
    chk("R7 ara blocked while fault", {7'd0, alert_n}, 8'h00);
    pulse_rd();
    chk("R5 persisting flags kept", status_q, 8'h28);
    local_val = 8'd10; remote_val = 8'd10;
    pulse_rd();
    pulse_rd();
    chk("R5 cleared after fault gone", status_q, 8'h00);
    chk("R7 latch held until ara", {7'd0, alert_n}, 8'h00);
    pulse_ara();
    chk("R7 ara clears", {7'd0, alert_n}, 8'h01);

    remote_val = 8'd200;
    pulse_rv();
    remote_val = 8'd10;
    pulse_rv();
    pulse_rd();
    chk("R4 sticky remote low", status_q, 8'h08);
    pulse_rd();
    chk("R4 cleared by read", status_q, 8'h00);

    busy = 1; sensor_open = 1;
    pulse_rv();
    sensor_open = 0;
    pulse_rd();
    chk("R2 busy and open bits", status_q, 8'h84);
    busy = 0;
    pulse_rd();
    chk("R2 open cleared", status_q, 8'h00);

    local_val = 8'd5; local_hi = 8'd2;
    @(negedge clk);
    pulse_rd();
    chk("R10 no strobe no flag", status_q, 8'h00);
    pulse_lw();
    pulse_rd();
    chk("R10 limit write evaluates", status_q, 8'h40);
    local_hi = 8'h7F;
    alert_mask = 1;
    @(negedge clk);
    chk("R8 mask hides latched alert", {7'd0, alert_n}, 8'h01);
    alert_mask = 0;
    @(negedge clk);
    chk("R8 unmask shows alert", {7'd0, alert_n}, 8'h00);
    pulse_rd(); pulse_ara();

    local_hi = 8'd40; local_lo = 8'hEC; remote_hi = 8'd10; remote_lo = 8'd10;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      int s;
      s = sx(v[7:0]);
      e = {1'b0, s > 40, s < -20, s > 10, s < 10, 3'b000};
      local_val = v[7:0]; remote_val = v[7:0];
      pulse_rv();
      pulse_rd();
      chk("R3 sweep compare", status_q, e);
      chk("R6 sweep alert", {7'd0, alert_n}, {7'd0, e == 8'h00});
      pulse_rd();
      chk("R5 sweep persist", status_q, e);
      local_val = 8'd10; remote_val = 8'd10;
      pulse_rd(); pulse_rd();
      chk("R5 sweep clear", status_q, 8'h00);
      pulse_ara();
      chk("R7 sweep ara", {7'd0, alert_n}, 8'h01);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule